// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor 24 general-purpose parallel lines through a four-location register window. The lines form two 8-bit ports, A and B, and a third 8-bit port, C, that is split into two nibbles. Software writes a configuration word that makes each port, and each Port C nibble on its own, an input or an output. That gives 16 direction combinations. Group A covers Port A and Port C bits 7:4. Group B covers Port B and Port C bits 3:0.

The processor side is synchronous. It has a chip select, read and write strobes, a 2-bit address, and separate data-in and data-out buses. One address holds the configuration register, and bit 7 of the written byte picks between two formats. When bit 7 is 1, the byte is a configuration word. When bit 7 is 0, the byte sets or clears a single Port C output bit.

Each pad has its own input bus, output bus and output-enable, so the block contains no tri-state logic. Every pin input passes through a multi-stage synchronizer before any read can see it.

Top module: `ppc_top`

## Requirements
- R1: After reset:
  - every output-enable is 0 and every output bus is 0;
  - reading the configuration address returns 8'h9B.
- R2: Address decode when cs is 1: 2'b00 is Port A, 2'b01 is Port B, 2'b10 is Port C and 2'b11 is the configuration register. Strobes given while cs is 0 change no output, no enable and no data-out value.
- R3: A write to 2'b11 with bit 7 = 1 is a configuration word:
  - bit 4 sets the direction of Port A;
  - bit 3 sets the direction of Port C bits 7:4;
  - bit 1 sets the direction of Port B;
  - bit 0 sets the direction of Port C bits 3:0.
  
  A direction bit of 1 means input, and each output-enable equals the inverse of its direction bit. The same write clears all three output registers to 0.
- R4: Reading the configuration register returns 1 in bit 7 and the four direction bits in their write positions (4, 3, 1, 0). Bits 6, 5 and 2 read 0 whatever was written to them.
- R5: A data write to a port or nibble configured as output updates that output bus at the clock edge that samples the write. A later read of that port returns the output register.
- R6: Data written to a port or nibble configured as input is dropped, so its output bus stays 0. This also applies to a single-bit command aimed at a Port C bit whose nibble is an input.
- R7: A write to 2'b11 with bit 7 = 0 is a single-bit command. Bits 3:1 give the Port C bit number and bit 0 gives its new value. At most that one Port C output bit changes, and Ports A and B keep their values.
- R8: Reading an input port or nibble returns the pin value after SYNC_STAGES flops. With two stages, a pin change presented before the edge in which a read is sampled first appears in the read sampled two edges later. A Port C read mixes the live pins of its input nibble with the register of its output nibble.
- R9: datao is registered. It takes the selected value at the edge that samples cs and rd both at 1, and it holds that value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| we | input | 1 | Write strobe |
| addr | input | 2 | Register address |
| datai | input | PORT_W | Write data |
| datao | output | PORT_W | Registered read data |
| porta_i | input | PORT_W | Port A pin inputs |
| portb_i | input | PORT_W | Port B pin inputs |
| portc_i | input | PORT_W | Port C pin inputs |
| porta_o | output | PORT_W | Port A output register |
| portb_o | output | PORT_W | Port B output register |
| portc_o | output | PORT_W | Port C output register |
| porta_oe | output | 1 | Port A output enable |
| portb_oe | output | 1 | Port B output enable |
| portc_oe | output | PORT_W | Port C per-pin output enables |

## Verification
The bench builds the block with PORT_W = 8 and SYNC_STAGES = 2. At these values the 3-bit single-bit field addresses all eight Port C bits, so the commands can hit both nibbles and their boundaries. With two synchronizer stages the pin-to-read latency is short enough to test exactly: three back-to-back reads after a pin change must return old, old, new. The bench also steps through configurations that mix input and output nibbles on Port C, so that dropped writes and mixed reads can be seen at the ports.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

    // Configuration byte layout (the format bit is decoded by the bus front end)
    localparam int CW_W      = 8;
    localparam int CW_FMT    = 7;
    localparam int CW_A_DIR  = 4;
    localparam int CW_CU_DIR = 3;
    localparam int CW_B_DIR  = 1;
    localparam int CW_CL_DIR = 0;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    // Direction state: 1 = input
    typedef struct packed {
        logic a_in;
        logic cu_in;
        logic b_in;
        logic cl_in;
    } dir_cfg_t;

    localparam dir_cfg_t DIR_ALL_IN = 4'b1111;

    // One-cycle command decoded from the bus
    typedef struct packed {
        logic rd_en;
        logic wr_a;
        logic wr_b;
        logic wr_c;
        logic wr_mode;
        logic wr_bit;
    } bus_cmd_t;

    function automatic dir_cfg_t mode_to_dir(input logic [CW_W-1:0] w);
        dir_cfg_t d;
        d.a_in  = w[CW_A_DIR];
        d.cu_in = w[CW_CU_DIR];
        d.b_in  = w[CW_B_DIR];
        d.cl_in = w[CW_CL_DIR];
        return d;
    endfunction

    function automatic logic [CW_W-1:0] dir_to_readback(input dir_cfg_t d);
        logic [CW_W-1:0] r;
        r            = '0;
        r[CW_FMT]    = 1'b1;
        r[CW_A_DIR]  = d.a_in;
        r[CW_CU_DIR] = d.cu_in;
        r[CW_B_DIR]  = d.b_in;
        r[CW_CL_DIR] = d.cl_in;
        return r;
    endfunction

endpackage

// File: rtl/ppc_sync.sv
module ppc_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ppc_decode.sv
module ppc_decode
    import ppc_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              cs,
    input  logic              rd,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [PORT_W-1:0] datai,
    output bus_cmd_t          cmd
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_comb begin
        cmd       = '0;
        cmd.rd_en = cs & rd;
        if (cs && we) begin
            unique case (sel)
                SEL_A:    cmd.wr_a = 1'b1;
                SEL_B:    cmd.wr_b = 1'b1;
                SEL_C:    cmd.wr_c = 1'b1;
                SEL_CTRL: begin
                    if (datai[CW_FMT]) cmd.wr_mode = 1'b1;
                    else               cmd.wr_bit  = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ppc_ctrl.sv
module ppc_ctrl
    import ppc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_mode,
    input  logic [CW_W-1:0] mode_word,
    output dir_cfg_t        dir,
    output logic [CW_W-1:0] readback
);
    always_ff @(posedge clk) begin
        if (rst)          dir <= DIR_ALL_IN;
        else if (wr_mode) dir <= mode_to_dir(mode_word);
    end

    assign readback = dir_to_readback(dir);
endmodule

// File: rtl/ppc_outreg.sv
module ppc_outreg #(
    parameter int W     = 8,
    parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             is_input,
    input  logic             wr,
    input  logic [W-1:0]     wr_data,
    input  logic             bit_wr,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    output logic [W-1:0]     q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (!is_input) begin
            if (wr)          q          <= wr_data;
            else if (bit_wr) q[bit_idx] <= bit_val;
        end
    end
endmodule

// File: rtl/ppc_rdpath.sv
module ppc_rdpath
    import ppc_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  dir_cfg_t          dir,
    input  logic [PORT_W-1:0] a_reg,
    input  logic [PORT_W-1:0] b_reg,
    input  logic [PORT_W-1:0] c_reg,
    input  logic [PORT_W-1:0] a_pin,
    input  logic [PORT_W-1:0] b_pin,
    input  logic [PORT_W-1:0] c_pin,
    input  logic [PORT_W-1:0] ctrl_rb,
    output logic [PORT_W-1:0] datao
);
    localparam int NIB = PORT_W / 2;

    logic [PORT_W-1:0] rd_val;
    logic [NIB-1:0]    c_hi;
    logic [NIB-1:0]    c_lo;

    assign c_hi = dir.cu_in ? c_pin[PORT_W-1:NIB] : c_reg[PORT_W-1:NIB];
    assign c_lo = dir.cl_in ? c_pin[NIB-1:0]      : c_reg[NIB-1:0];

    always_comb begin
        unique case (reg_sel_e'(addr))
            SEL_A:   rd_val = dir.a_in ? a_pin : a_reg;
            SEL_B:   rd_val = dir.b_in ? b_pin : b_reg;
            SEL_C:   rd_val = {c_hi, c_lo};
            default: rd_val = ctrl_rb;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        datao <= '0;
        else if (rd_en) datao <= rd_val;
    end
endmodule

// File: rtl/ppc_top.sv
module ppc_top
    import ppc_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              rd,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [PORT_W-1:0] datai,
    output logic [PORT_W-1:0] datao,
    input  logic [PORT_W-1:0] porta_i,
    input  logic [PORT_W-1:0] portb_i,
    input  logic [PORT_W-1:0] portc_i,
    output logic [PORT_W-1:0] porta_o,
    output logic [PORT_W-1:0] portb_o,
    output logic [PORT_W-1:0] portc_o,
    output logic              porta_oe,
    output logic              portb_oe,
    output logic [PORT_W-1:0] portc_oe
);
    localparam int NIB    = PORT_W / 2;
    localparam int CSEL_W = $clog2(PORT_W);
    localparam int NIDX_W = $clog2(NIB);

    bus_cmd_t          cmd;
    dir_cfg_t          dir;
    logic [CW_W-1:0]   ctrl_rb;
    logic [3*PORT_W-1:0] pins_s;
    logic [PORT_W-1:0] a_reg, b_reg, c_reg;

    ppc_decode #(.PORT_W(PORT_W)) u_decode (
        .cs(cs), .rd(rd), .we(we), .addr(addr), .datai(datai), .cmd(cmd)
    );

    ppc_ctrl u_ctrl (
        .clk(clk), .rst(rst), .wr_mode(cmd.wr_mode),
        .mode_word(datai[CW_W-1:0]), .dir(dir), .readback(ctrl_rb)
    );

    ppc_sync #(.W(3*PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d({porta_i, portb_i, portc_i}), .q(pins_s)
    );

    ppc_outreg #(.W(PORT_W)) u_areg (
        .clk(clk), .rst(rst), .clr(cmd.wr_mode), .is_input(dir.a_in),
        .wr(cmd.wr_a), .wr_data(datai), .bit_wr(1'b0), .bit_idx('0),
        .bit_val(1'b0), .q(a_reg)
    );

    ppc_outreg #(.W(PORT_W)) u_breg (
        .clk(clk), .rst(rst), .clr(cmd.wr_mode), .is_input(dir.b_in),
        .wr(cmd.wr_b), .wr_data(datai), .bit_wr(1'b0), .bit_idx('0),
        .bit_val(1'b0), .q(b_reg)
    );

    // Port C: one register slice per nibble, each with its own direction
    for (genvar n = 0; n < 2; n++) begin : g_cnib
        logic nib_in;
        logic bit_hit;
        assign nib_in  = (n == 1) ? dir.cu_in : dir.cl_in;
        assign bit_hit = cmd.wr_bit && (datai[CSEL_W] == 1'(n));

        ppc_outreg #(.W(NIB)) u_creg (
            .clk(clk), .rst(rst), .clr(cmd.wr_mode), .is_input(nib_in),
            .wr(cmd.wr_c), .wr_data(datai[n*NIB +: NIB]),
            .bit_wr(bit_hit), .bit_idx(datai[NIDX_W:1]), .bit_val(datai[0]),
            .q(c_reg[n*NIB +: NIB])
        );
    end

    ppc_rdpath #(.PORT_W(PORT_W)) u_rdpath (
        .clk(clk), .rst(rst), .rd_en(cmd.rd_en), .addr(addr), .dir(dir),
        .a_reg(a_reg), .b_reg(b_reg), .c_reg(c_reg),
        .a_pin(pins_s[3*PORT_W-1:2*PORT_W]),
        .b_pin(pins_s[2*PORT_W-1:PORT_W]),
        .c_pin(pins_s[PORT_W-1:0]),
        .ctrl_rb(ctrl_rb), .datao(datao)
    );

    assign porta_o  = a_reg;
    assign portb_o  = b_reg;
    assign portc_o  = c_reg;
    assign porta_oe = ~dir.a_in;
    assign portb_oe = ~dir.b_in;
    assign portc_oe = {{NIB{~dir.cu_in}}, {NIB{~dir.cl_in}}};
endmodule

// File: rtl/ppc_checker.sv
module ppc_checker #(
    parameter int PORT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cs,
    input logic              rd,
    input logic              we,
    input logic [1:0]        addr,
    input logic [PORT_W-1:0] datai,
    input logic [PORT_W-1:0] datao,
    input logic [PORT_W-1:0] porta_o,
    input logic [PORT_W-1:0] portb_o,
    input logic [PORT_W-1:0] portc_o,
    input logic              porta_oe,
    input logic              portb_oe,
    input logic [PORT_W-1:0] portc_oe
);
    logic cfg_wr, bit_cmd, cfg_rd;
    assign cfg_wr  = cs && we && (addr == 2'b11) && datai[7];
    assign bit_cmd = cs && we && (addr == 2'b11) && !datai[7];
    assign cfg_rd  = cs && rd && (addr == 2'b11);

    assert_no_cs_effect_R2: assert property (@(posedge clk) disable iff (rst)
        !cs |=> ($stable(porta_o) && $stable(portb_o) && $stable(portc_o) &&
                 $stable(porta_oe) && $stable(portb_oe) && $stable(portc_oe) &&
                 $stable(datao)));

    assert_cfg_clears_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (porta_o == '0 && portb_o == '0 && portc_o == '0));

    assert_cfg_dir_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (porta_oe == !$past(datai[4]) && portb_oe == !$past(datai[1])));

    assert_readback_msb_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_rd |=> datao[7]);

    assert_input_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        ((porta_oe || porta_o == '0) && (portb_oe || portb_o == '0) &&
         ((portc_o & ~portc_oe) == '0)));

    assert_single_bit_R7: assert property (@(posedge clk) disable iff (rst)
        bit_cmd |=> ($countones(portc_o ^ $past(portc_o)) <= 1 &&
                     $stable(porta_o) && $stable(portb_o)));

    assert_datao_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(cs && rd) |=> $stable(datao));
endmodule

bind ppc_top ppc_checker #(.PORT_W(PORT_W)) u_chk (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .we(we), .addr(addr),
    .datai(datai), .datao(datao), .porta_o(porta_o), .portb_o(portb_o),
    .portc_o(portc_o), .porta_oe(porta_oe), .portb_oe(portb_oe),
    .portc_oe(portc_oe)
);

// File: tb/tb_ppc_top.sv
`timescale 1ns/1ps
module tb_ppc_top;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs = 0, rd = 0, we = 0;
    logic [1:0]    addr = '0;
    logic [PW-1:0] datai = '0;
    logic [PW-1:0] datao;
    logic [PW-1:0] porta_i = '0, portb_i = '0, portc_i = '0;
    logic [PW-1:0] porta_o, portb_o, portc_o, portc_oe;
    logic          porta_oe, portb_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic [PW-1:0] exp;
        string         tag;
    } exp_t;
    exp_t sb[$];
    logic rd_seen = 1'b0;

    always #2 clk = ~clk;

    ppc_top #(.PORT_W(PW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .cs(cs), .rd(rd), .we(we), .addr(addr),
        .datai(datai), .datao(datao), .porta_i(porta_i), .portb_i(portb_i),
        .portc_i(portc_i), .porta_o(porta_o), .portb_o(portb_o),
        .portc_o(portc_o), .porta_oe(porta_oe), .portb_oe(portb_oe),
        .portc_oe(portc_oe)
    );

    // Monitor: a read sampled at a posedge is checked at the following negedge
    always @(posedge clk) rd_seen <= cs & rd & ~rst;

    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: unexpected read, datao=%02h expected none", datao);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (datao !== e.exp) begin
                    errors++;
                    $display("FAIL %s: datao=%02h expected %02h", e.tag, datao, e.exp);
                end
            end
        end
    end

    task automatic check(input logic [PW-1:0] act, input logic [PW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_idle();
        @(negedge clk);
        cs = 0; rd = 0; we = 0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [PW-1:0] d);
        @(negedge clk);
        cs = 1; we = 1; rd = 0; addr = a; datai = d;
        @(negedge clk);
        cs = 0; we = 0;
    endtask

    // Issues one read cycle and leaves the strobe up for back-to-back use
    task automatic read_issue(input logic [1:0] a, input logic [PW-1:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        cs = 1; rd = 1; we = 0; addr = a;
        e.exp = exp; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [PW-1:0] exp, input string tag);
        read_issue(a, exp, tag);
        bus_idle();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        check({7'd0, porta_oe}, 8'h00, "R1 porta_oe");
        check({7'd0, portb_oe}, 8'h00, "R1 portb_oe");
        check(portc_oe, 8'h00, "R1 portc_oe");
        check(porta_o | portb_o | portc_o, 8'h00, "R1 outputs");
        bus_read(2'b11, 8'h9B, "R1 R4 reset readback");

        // R3 all outputs
        bus_write(2'b11, 8'h80);
        check({6'd0, porta_oe, portb_oe}, 8'h03, "R3 A/B enables");
        check(portc_oe, 8'hFF, "R3 C enables");
        bus_read(2'b11, 8'h80, "R4 readback all out");

        // R5 / R2 data writes and readback
        bus_write(2'b00, 8'h5A);
        bus_write(2'b01, 8'hC3);
        bus_write(2'b10, 8'h96);
        check(porta_o, 8'h5A, "R5 porta_o");
        check(portb_o, 8'hC3, "R5 portb_o");
        check(portc_o, 8'h96, "R5 portc_o");
        bus_read(2'b00, 8'h5A, "R2 R5 read A");
        bus_read(2'b01, 8'hC3, "R2 R5 read B");
        bus_read(2'b10, 8'h96, "R2 R5 read C");

        // R2 strobes without chip select
        @(negedge clk);
        cs = 0; we = 1; addr = 2'b00; datai = 8'hFF;
        @(negedge clk);
        we = 0; rd = 1; addr = 2'b11;
        @(negedge clk);
        rd = 0;
        check(porta_o, 8'h5A, "R2 no-cs write");
        check(datao, 8'h96, "R2 R9 no-cs read holds datao");

        // R7 single-bit commands
        bus_write(2'b11, 8'h01);  // bit 0 set
        check(portc_o, 8'h97, "R7 set C0");
        bus_write(2'b11, 8'h08);  // bit 4 clear
        check(portc_o, 8'h87, "R7 clear C4");
        check(porta_o, 8'h5A, "R7 A untouched");

        // R3 / R4 mode word with unused bits set
        bus_write(2'b11, 8'hE4);
        check(porta_o | portb_o | portc_o, 8'h00, "R3 mode clears outputs");
        bus_read(2'b11, 8'h80, "R4 unused bits read 0");

        // R6 / R8 A and B inputs, C output
        bus_write(2'b11, 8'h92);
        porta_i = 8'h3C; portb_i = 8'hA5;
        bus_write(2'b00, 8'hFF);
        check(porta_o, 8'h00, "R6 write to input A dropped");
        check({6'd0, porta_oe, portb_oe}, 8'h00, "R3 A/B input enables");
        bus_read(2'b00, 8'h3C, "R8 read A pins");
        bus_read(2'b01, 8'hA5, "R8 read B pins");
        bus_write(2'b11, 8'h0B);  // bit 5 set
        check(portc_o, 8'h20, "R7 set C5");

        // R6 / R7 / R8 mixed Port C nibbles: upper input, lower output
        bus_write(2'b11, 8'h88);
        check(portc_oe, 8'h0F, "R3 C mixed enables");
        portc_i = 8'h5A;
        bus_write(2'b10, 8'hFF);
        check(portc_o, 8'h0F, "R6 C upper nibble dropped");
        bus_read(2'b10, 8'h5F, "R8 mixed C read");
        bus_write(2'b11, 8'h0F);  // bit 7 set, nibble is input
        check(portc_o, 8'h0F, "R6 R7 bit command on input nibble");
        bus_write(2'b11, 8'h02);  // bit 1 clear
        check(portc_o, 8'h0D, "R7 clear C1");
        bus_read(2'b10, 8'h5D, "R8 mixed C read after bit clear");

        // R8 synchronizer latency, R9 hold
        bus_write(2'b11, 8'h90);
        porta_i = 8'h11;
        repeat (3) @(negedge clk);
        read_issue(2'b00, 8'h11, "R8 latency read 0");
        porta_i = 8'h22;
        read_issue(2'b00, 8'h11, "R8 latency read 1");
        read_issue(2'b00, 8'h22, "R8 latency read 2");
        bus_idle();
        repeat (3) @(negedge clk);
        check(datao, 8'h22, "R9 datao holds between reads");

        repeat (2) @(negedge clk);
        check(8'(sb.size()), 8'h00, "scoreboard drained");
        finish_run();
    end
endmodule